// File: doc/BRIEF.md
# Configuration Stream Word Aligner and Packet Router

This block takes a configuration stream one byte at a time and finds where its 32-bit words begin. Until it is aligned it compares the last four bytes received with a fixed synchronisation pattern. This comparison runs on every accepted byte, so the pattern may start at any byte offset. Padding words of all ones and any other bytes seen before the pattern have no effect. Once the pattern has matched, the byte that follows it starts the first 32-bit word. Bytes are packed most significant first.

After alignment, each word is a packet header or a payload word. A write header of type one names a target register and a word count. The payload words that follow are routed in one of two ways. Words for the frame-data register appear on the write-data bus with a frame strobe. Words for any other register appear with a register write enable and the register address. A header of any type other than one means alignment has been lost. The block then drops its synced flag and goes back to hunting for the pattern.

Top module: `cfg_stream_parser`

## Requirements
- R1: After reset `synced`, `reg_we` and `frame_we` are all 0.
- R2: While `synced` is 0, no byte content leads to a write, including leading 0xFFFFFFFF padding and well-formed headers. This holds for every byte up to and including the last byte of the pattern.
- R3: When the four most recent accepted bytes equal 0xAA995566 (default `SYNC_PATTERN`), `synced` is 1 from the next clock edge on. This holds at any byte offset in the stream.
- R4: The four accepted bytes after the pattern form the first word, with the first byte in bits 31:24. Later words follow every four accepted bytes.
- R5: A header with bits 31:29 = 001 and bits 28:27 = 10 is a write. It carries the register address in bits 17:13 and the count N in bits 10:0. Each of the next N words gives one `reg_we` pulse, with `reg_addr` set to that address and `reg_wdata` set to the word. The pulse comes one cycle after the word's last byte.
- R6: When the header address equals `FRAME_REG` (default 2), the payload words pulse `frame_we` instead of `reg_we`, and `reg_wdata` carries each word.
- R7: A write header with count 0 causes no write, and the word after it is decoded as a header.
- R8: A header with bits 31:29 = 001 and bits 28:27 other than 10 is consumed with no write. `synced` stays 1 and the next word is a header.
- R9: A header whose bits 31:29 are not 001 causes no write and clears `synced` at the next edge. The pattern search then restarts, and a later pattern aligns the stream again.
- R10: `reg_we` and `frame_we` are never 1 together, and each pulses for one cycle per payload word.
- R11: Cycles with `byte_vld` low are ignored, so idle gaps inside a word do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Byte qualifier |
| byte_data | input | 8 | Stream byte |
| synced | output | 1 | Word alignment established |
| reg_addr | output | 5 | Target register of the current write |
| reg_wdata | output | 32 | Payload word |
| reg_we | output | 1 | Register write pulse |
| frame_we | output | 1 | Frame-data word pulse |

## Verification
The hardest situation to reach is loss of alignment followed by a new alignment at a different byte phase. The bench sends a header with an invalid type in the middle of a valid stream. It then sends a well-formed write header while the block is unsynced, which must be ignored. After that it sends a new pattern preceded by two odd bytes, one of which matches the pattern's first byte. Gaps between the bytes of a word, a zero-count header and a non-write type-one header are placed between ordinary writes. If the block slipped a byte, the scoreboard would see wrong data.

// File: rtl/cfg_parser_pkg.sv
package cfg_parser_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = 11;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic {PS_HDR, PS_DATA} parse_st_t;

  function automatic logic [2:0] hdr_kind(input logic [WORD_W-1:0] w);
    return w[31:29];
  endfunction

  function automatic logic hdr_writes(input logic [WORD_W-1:0] w);
    return w[28:27] == 2'b10;
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_target(input logic [WORD_W-1:0] w);
    return w[13 +: ADDR_W];
  endfunction

  function automatic logic [CNT_W-1:0] hdr_len(input logic [WORD_W-1:0] w);
    return w[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/cfg_sync_hunter.sv
module cfg_sync_hunter
  import cfg_parser_pkg::*;
#(
  parameter logic [WORD_W-1:0] SYNC_PATTERN = 32'hAA995566
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              resync,
  output logic              synced,
  output logic              sync_hit,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] window_q;
  logic [LANE_W-1:0] lane_q;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  assign word     = {window_q[WORD_W-BYTE_W-1:0], byte_data};
  assign sync_hit = !synced && byte_vld && (word == SYNC_PATTERN);
  assign word_vld = synced && byte_vld && (lane_q == LAST_LANE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      window_q <= '0;
      lane_q   <= '0;
      synced   <= 1'b0;
    end else begin
      if (byte_vld) window_q <= resync ? '0 : word;
      if (sync_hit) begin
        synced <= 1'b1;
        lane_q <= '0;
      end else if (resync) begin
        synced <= 1'b0;
        lane_q <= '0;
      end else if (synced && byte_vld) begin
        lane_q <= lane_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_pkt_router.sv
module cfg_pkt_router
  import cfg_parser_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FRAME_REG = 5'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              synced,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  output logic              resync,
  output logic              hdr_phase,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              frame_we
);
  parse_st_t        st_q;
  logic [CNT_W-1:0] left_q;
  logic             type_ok;
  logic             wr_start;

  assign hdr_phase = (st_q == PS_HDR);
  assign type_ok   = (hdr_kind(word) == 3'b001);
  assign resync    = synced && word_vld && hdr_phase && !type_ok;
  assign wr_start  = type_ok && hdr_writes(word) && (hdr_len(word) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= PS_HDR;
      left_q    <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      frame_we  <= 1'b0;
    end else begin
      reg_we   <= 1'b0;
      frame_we <= 1'b0;
      if (!synced) begin
        st_q <= PS_HDR;
      end else if (word_vld) begin
        if (hdr_phase) begin
          if (wr_start) begin
            reg_addr <= hdr_target(word);
            left_q   <= hdr_len(word);
            st_q     <= PS_DATA;
          end
        end else begin
          reg_wdata <= word;
          if (reg_addr == FRAME_REG) frame_we <= 1'b1;
          else                       reg_we   <= 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) st_q <= PS_HDR;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
  import cfg_parser_pkg::*;
#(
  parameter logic [WORD_W-1:0] SYNC_PATTERN = 32'hAA995566,
  parameter logic [ADDR_W-1:0] FRAME_REG    = 5'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              synced,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              frame_we
);
  logic              sync_hit;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic              resync;
  logic              hdr_phase;

  cfg_sync_hunter #(.SYNC_PATTERN(SYNC_PATTERN)) u_hunt (
    .clk, .rst_n, .byte_vld, .byte_data, .resync,
    .synced, .sync_hit, .word_vld, .word
  );

  cfg_pkt_router #(.FRAME_REG(FRAME_REG)) u_route (
    .clk, .rst_n, .synced, .word_vld, .word, .resync, .hdr_phase,
    .reg_addr, .reg_wdata, .reg_we, .frame_we
  );
endmodule

// File: rtl/cfg_stream_parser_chk.sv
module cfg_stream_parser_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_vld,
  input logic synced,
  input logic reg_we,
  input logic frame_we,
  input logic word_vld,
  input logic sync_hit,
  input logic resync,
  input logic hdr_phase
);
  AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && frame_we)); // R10
  AST_WRITE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || frame_we) |-> $past(synced)); // R2
  AST_WRITE_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || frame_we) |-> $past(word_vld)); // R5
  AST_HIT_ALIGNS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> synced); // R3
  AST_BAD_TYPE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !synced); // R9
  AST_HEADER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && hdr_phase) |=> !(reg_we || frame_we)); // R7
  AST_GAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> !(reg_we || frame_we)); // R11
endmodule

bind cfg_stream_parser cfg_stream_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .synced(synced),
  .reg_we(reg_we), .frame_we(frame_we), .word_vld(word_vld),
  .sync_hit(sync_hit), .resync(resync), .hdr_phase(hdr_phase)
);

// File: tb/tb_cfg_stream_parser.sv
module tb_cfg_stream_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        synced;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic        frame_we;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [37:0] expq[$];

  always #2.5 clk = ~clk;

  cfg_stream_parser dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    byte_vld  = 1'b1;
    byte_data = b;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      byte_vld = 1'b0;
    end
  endtask

  task automatic send_word(input logic [31:0] w, input bit gaps);
    for (int i = 3; i >= 0; i--) begin
      send_byte(w[i*8 +: 8]);
      if (gaps && i != 0) idle(2);
    end
  endtask

  // Expected item: {is_frame, addr, data}
  task automatic exp_write(input bit is_frame, input logic [4:0] a, input logic [31:0] d);
    expq.push_back({is_frame, a, d});
  endtask

  // Monitor: every strobe pops one expected item (R5, R6, R10)
  always @(negedge clk) begin
    if (rst_n && (reg_we || frame_we)) begin
      check(!(reg_we && frame_we), "R10", "both strobes", {reg_we, frame_we}, 2'b00);
      if (expq.size() == 0) begin
        check(1'b0, "R2", "unexpected write", {reg_addr, reg_wdata}, 0);
      end else begin
        logic [37:0] e;
        e = expq.pop_front();
        if (e[37]) check(frame_we && reg_wdata == e[31:0], "R6", "frame word",
                         {frame_we, reg_wdata}, {1'b1, e[31:0]});
        else check(reg_we && reg_addr == e[36:32] && reg_wdata == e[31:0], "R5",
                   "register write", {reg_we, reg_addr, reg_wdata}, {1'b1, e[36:0]});
      end
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(synced == 0 && reg_we == 0 && frame_we == 0, "R1", "reset outputs",
          {synced, reg_we, frame_we}, 0);
    rst_n = 1'b1;
    // R2: padding and a header before sync do nothing
    send_word(32'hFFFFFFFF, 0);
    send_word(32'hFFFFFFFF, 0);
    send_word(32'h30008001, 0);
    send_word(32'h00000007, 0);
    idle(1);
    check(synced == 0, "R2", "synced before pattern", synced, 0);
    // R3: pattern at an odd offset
    send_byte(8'h12);
    send_word(32'hAA995566, 0);
    idle(1);
    check(synced == 1, "R3", "synced after pattern", synced, 1);
    // R4/R11: first word with byte gaps
    exp_write(0, 5'd4, 32'h00000007);
    send_word(32'h30008001, 1);
    send_word(32'h00000007, 1);
    exp_write(0, 5'd11, 32'h00000005);
    send_word(32'h30016001, 0);
    send_word(32'h00000005, 0);
    exp_write(0, 5'd9, 32'hDEADBEEF);
    send_word(32'h30012001, 0);
    send_word(32'hDEADBEEF, 0);
    // R7: zero count, next word is header
    send_word(32'h30010000, 0);
    exp_write(0, 5'd1, 32'h00A00000);
    send_word(32'h30002001, 0);
    send_word(32'h00A00000, 0);
    // R8: type-1 non-write header
    send_word(32'h20000000, 0);
    idle(1);
    check(synced == 1, "R8", "synced after non-write header", synced, 1);
    exp_write(0, 5'd4, 32'h00000009);
    send_word(32'h30008001, 0);
    send_word(32'h00000009, 0);
    // R6: frame data
    send_word(32'h30004003, 0);
    for (int k = 0; k < 3; k++) begin
      exp_write(1, 5'd2, 32'hC0DE0000 + k);
      send_word(32'hC0DE0000 + k, 0);
    end
    // R5: multi-word register write
    send_word(32'h3000C002, 0);
    exp_write(0, 5'd6, 32'h11112222);
    send_word(32'h11112222, 0);
    exp_write(0, 5'd6, 32'h33334444);
    send_word(32'h33334444, 0);
    idle(2);
    check(expq.size() == 0, "R5", "pending writes", expq.size(), 0);
    // R9: bad type drops sync, then realign at another offset
    send_word(32'hFFFFFFFF, 0);
    idle(1);
    check(synced == 0, "R9", "synced after bad header", synced, 0);
    send_word(32'h30008001, 0);
    send_word(32'h00000001, 0);
    idle(1);
    check(synced == 0, "R9", "still unsynced", synced, 0);
    send_byte(8'h00);
    send_byte(8'hAA);
    send_word(32'hAA995566, 0);
    idle(1);
    check(synced == 1, "R9", "resynced", synced, 1);
    exp_write(0, 5'd4, 32'h00000001);
    send_word(32'h30008001, 0);
    send_word(32'h00000001, 0);
    idle(4);
    check(expq.size() == 0, "R4", "all writes seen", expq.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule